// File: doc/BRIEF.md
# Adaptive Slip Control Queue

This block is a data-less token queue placed between a prefetching unit and the load-issuing unit that trails it. The prefetch side puts one token for each loop iteration, and the load side takes one token for each iteration. The occupancy therefore bounds how far the prefetcher can run ahead of the loads.

The number of tokens the queue accepts is a run-time capacity limit. The limit moves up or down by one step at each adaptation point. Two saturating counters drive the decision: one counts prefetches whose data arrived too late, the other counts prefetches whose data arrived in time. A status input freezes the limit while the prefetch buffer is full. An adaptation point is either an explicit strobe or the moment a programmable number of outcome events has been collected, whichever comes first.

Top module: `adaptive_slip_queue`

## Requirements
- R1: After reset, occupancy is 0 and the limit equals INIT_DEPTH (4 by default).
- R2: put_ready is high exactly when occupancy is below the limit. A put made while put_ready is low leaves occupancy unchanged.
- R3: get_ready is high exactly when occupancy is nonzero. A get made at occupancy 0 leaves occupancy at 0.
- R4: Each accepted put adds one to occupancy and each accepted get removes one. A put and a get accepted in the same cycle leave occupancy unchanged.
- R5: At an adaptation point with pbuf_full high, the limit keeps its value.
- R6: At an adaptation point with pbuf_full low, if twice the late count is greater than the useful count, the limit rises by one, saturating at MAX_DEPTH (16 by default). The doubled value is formed one bit wider, so it never overflows.
- R7: At an adaptation point with pbuf_full low where R6 does not apply, the limit falls by one, saturating at MIN_DEPTH (2 by default). Outside adaptation points the limit never changes.
- R8: An adaptation point occurs when adapt_strobe is high. It also occurs when evt_window is nonzero and the number of outcome events since the last adaptation, including this cycle's late_evt and useful_evt pulses (each counts as one), reaches evt_window. When evt_window is 0, only the strobe adapts.
- R9: The decision at an adaptation point uses counts that include that cycle's pulses. The late, useful and event counts then restart from zero.
- R10: When the limit falls below occupancy, no tokens are lost. Puts stay blocked until occupancy is below the new limit.
- R11: The late and useful counters are 16 bits wide and saturate at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| put_valid | input | 1 | Prefetch side requests to deposit a token |
| put_ready | output | 1 | A put is accepted this cycle |
| get_valid | input | 1 | Load side requests to remove a token |
| get_ready | output | 1 | A get is accepted this cycle |
| late_evt | input | 1 | Pulse: one prefetch arrived late |
| useful_evt | input | 1 | Pulse: one prefetch arrived in time |
| adapt_strobe | input | 1 | Forces an adaptation point |
| pbuf_full | input | 1 | Prefetch buffer full; freezes the limit |
| evt_window | input | EVT_W (8) | Event count that triggers adaptation; 0 disables this trigger |
| cur_limit | output | DW (5) | Current capacity limit |
| occupancy | output | DW (5) | Tokens currently held |

## Verification
On every cycle, the embedded assertions check these properties: a refused put or get leaves occupancy unchanged, a put and a get in the same cycle cancel, the limit moves only at adaptation points and stays put when the buffer is full, the counters clear after each adaptation, and the limit stays inside its bounds. The direction of each adjustment, the triggering by the event window, the case where the limit shrinks below occupancy, and the saturation of the counters near 65535 need a reference model. Only the bench scenarios show these: long directed runs of events plus random traffic, compared against that model.

// File: rtl/slip_pkg.sv
package slip_pkg;
    typedef enum logic [1:0] {
        ADJ_HOLD   = 2'd0,
        ADJ_GROW   = 2'd1,
        ADJ_SHRINK = 2'd2
    } adj_e;
endpackage

// File: rtl/slip_feedback.sv
module slip_feedback
    import slip_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             late_evt,
    input  logic             useful_evt,
    input  logic             adapt_strobe,
    input  logic             pbuf_full,
    input  logic [EVT_W-1:0] evt_window,
    output logic             fire,
    output adj_e             adj
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [EVT_W:0]   EVT_MAX = {1'b0, {EVT_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] late;
        logic [CNT_W-1:0] useful;
        logic [EVT_W-1:0] evts;
    } fb_t;

    fb_t fb_d, fb_q;
    logic [CNT_W-1:0] late_nx, useful_nx;
    logic [EVT_W:0]   evt_sum;
    logic             trig;

    always_comb begin
        late_nx   = (fb_q.late   == CNT_MAX) ? fb_q.late   : fb_q.late   + CNT_W'(late_evt);
        useful_nx = (fb_q.useful == CNT_MAX) ? fb_q.useful : fb_q.useful + CNT_W'(useful_evt);
        evt_sum   = {1'b0, fb_q.evts} + (EVT_W+1)'(late_evt) + (EVT_W+1)'(useful_evt);
        trig      = adapt_strobe ||
                    ((evt_window != '0) && (evt_sum >= {1'b0, evt_window}));
        adj = ADJ_HOLD;
        if (trig && !pbuf_full) begin
            if ({late_nx, 1'b0} > {1'b0, useful_nx}) adj = ADJ_GROW;
            else                                     adj = ADJ_SHRINK;
        end
        fb_d = fb_q;
        if (trig) begin
            fb_d = '0;
        end else begin
            fb_d.late   = late_nx;
            fb_d.useful = useful_nx;
            fb_d.evts   = (evt_sum > EVT_MAX) ? EVT_MAX[EVT_W-1:0] : evt_sum[EVT_W-1:0];
        end
        fire = trig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    // R9: counts restart after every adaptation point
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (fb_q.late == '0 && fb_q.useful == '0 && fb_q.evts == '0));
    // R11: a saturated counter stays saturated until cleared
    a_r11_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_q.late == CNT_MAX && !fire) |=> fb_q.late == CNT_MAX);
endmodule

// File: rtl/slip_limit.sv
module slip_limit
    import slip_pkg::*;
#(
    parameter int DW         = 5,
    parameter int MIN_DEPTH  = 2,
    parameter int MAX_DEPTH  = 16,
    parameter int INIT_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  adj_e          adj,
    input  logic          pbuf_full,
    output logic [DW-1:0] limit
);
    localparam logic [DW-1:0] LIM_MIN  = DW'(MIN_DEPTH);
    localparam logic [DW-1:0] LIM_MAX  = DW'(MAX_DEPTH);
    localparam logic [DW-1:0] LIM_INIT = DW'(INIT_DEPTH);

    logic [DW-1:0] limit_d, limit_q;

    always_comb begin
        limit_d = limit_q;
        unique case (adj)
            ADJ_GROW:   if (limit_q < LIM_MAX) limit_d = limit_q + 1'b1;
            ADJ_SHRINK: if (limit_q > LIM_MIN) limit_d = limit_q - 1'b1;
            default:    limit_d = limit_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) limit_q <= LIM_INIT;
        else        limit_q <= limit_d;
    end

    assign limit = limit_q;

    // R5: buffer-full freezes the limit
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pbuf_full) |=> $stable(limit_q));
    // R7: no change outside an adaptation point
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(limit_q));

    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r6_bounds: assert (limit_q >= LIM_MIN && limit_q <= LIM_MAX);
        end
    end
endmodule

// File: rtl/slip_occupancy.sv
module slip_occupancy #(
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          put_valid,
    input  logic          get_valid,
    input  logic [DW-1:0] limit,
    output logic          put_ready,
    output logic          get_ready,
    output logic [DW-1:0] occ
);
    logic [DW-1:0] occ_d, occ_q;
    logic          put_acc, get_acc;

    always_comb begin
        put_ready = (occ_q < limit);
        get_ready = (occ_q != '0);
        put_acc   = put_valid && put_ready;
        get_acc   = get_valid && get_ready;
        occ_d     = occ_q;
        if (put_acc && !get_acc) occ_d = occ_q + 1'b1;
        if (get_acc && !put_acc) occ_d = occ_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign occ = occ_q;

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (put_valid && !put_ready && !get_valid) |=> $stable(occ_q));
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (get_valid && occ_q == '0 && !put_valid) |=> occ_q == '0);
    a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (put_valid && put_ready && get_valid && get_ready) |=> $stable(occ_q));
endmodule

// File: rtl/adaptive_slip_queue.sv
module adaptive_slip_queue
    import slip_pkg::*;
#(
    parameter int MIN_DEPTH  = 2,
    parameter int MAX_DEPTH  = 16,
    parameter int INIT_DEPTH = 4,
    parameter int CNT_W      = 16,
    parameter int EVT_W      = 8,
    localparam int DW        = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             put_valid,
    output logic             put_ready,
    input  logic             get_valid,
    output logic             get_ready,
    input  logic             late_evt,
    input  logic             useful_evt,
    input  logic             adapt_strobe,
    input  logic             pbuf_full,
    input  logic [EVT_W-1:0] evt_window,
    output logic [DW-1:0]    cur_limit,
    output logic [DW-1:0]    occupancy
);
    logic fire;
    adj_e adj;

    slip_feedback #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_fb (
        .clk(clk), .rst_n(rst_n), .late_evt(late_evt), .useful_evt(useful_evt),
        .adapt_strobe(adapt_strobe), .pbuf_full(pbuf_full),
        .evt_window(evt_window), .fire(fire), .adj(adj)
    );

    slip_limit #(.DW(DW), .MIN_DEPTH(MIN_DEPTH), .MAX_DEPTH(MAX_DEPTH),
                 .INIT_DEPTH(INIT_DEPTH)) u_lim (
        .clk(clk), .rst_n(rst_n), .fire(fire), .adj(adj),
        .pbuf_full(pbuf_full), .limit(cur_limit)
    );

    slip_occupancy #(.DW(DW)) u_occ (
        .clk(clk), .rst_n(rst_n), .put_valid(put_valid), .get_valid(get_valid),
        .limit(cur_limit), .put_ready(put_ready), .get_ready(get_ready),
        .occ(occupancy)
    );

    // R10: tokens above a lowered limit are kept, never dropped
    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy > cur_limit && !get_valid) |=> $stable(occupancy));
endmodule

// File: tb/sim_adaptive_slip_queue.sv
module sim_adaptive_slip_queue;
    localparam int MIN_D = 2, MAX_D = 16, INIT_D = 4, EVT_W = 8, DW = 5;

    logic clk = 0, rst_n = 0;
    logic put_valid = 0, get_valid = 0, late_evt = 0, useful_evt = 0;
    logic adapt_strobe = 0, pbuf_full = 0;
    logic [EVT_W-1:0] evt_window = 0;
    logic put_ready, get_ready;
    logic [DW-1:0] cur_limit, occupancy;

    int n_tests = 0, n_fail = 0;
    int m_occ, m_lim, m_late, m_use, m_evt;

    always #2 clk = ~clk;

    adaptive_slip_queue #(.MIN_DEPTH(MIN_D), .MAX_DEPTH(MAX_D), .INIT_DEPTH(INIT_D),
                          .EVT_W(EVT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .put_valid(put_valid), .put_ready(put_ready),
        .get_valid(get_valid), .get_ready(get_ready), .late_evt(late_evt),
        .useful_evt(useful_evt), .adapt_strobe(adapt_strobe), .pbuf_full(pbuf_full),
        .evt_window(evt_window), .cur_limit(cur_limit), .occupancy(occupancy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic step(input bit pv, input bit gv, input bit le, input bit ue,
                        input bit as, input bit pf);
        bit pa, ga, trig;
        int nl, nu, sum;
        put_valid = pv; get_valid = gv; late_evt = le; useful_evt = ue;
        adapt_strobe = as; pbuf_full = pf;
        #1;
        chk(put_ready == (m_occ < m_lim), "R2 put_ready", int'(put_ready), int'(m_occ < m_lim));
        chk(get_ready == (m_occ != 0), "R3 get_ready", int'(get_ready), int'(m_occ != 0));
        pa = pv && (m_occ < m_lim);
        ga = gv && (m_occ != 0);
        m_occ = m_occ + int'(pa) - int'(ga);
        nl = sat16(m_late + int'(le));
        nu = sat16(m_use + int'(ue));
        sum = m_evt + int'(le) + int'(ue);
        trig = as || (evt_window != 0 && sum >= int'(evt_window));
        if (trig) begin
            if (!pf) begin
                if (2 * nl > nu) m_lim = (m_lim < MAX_D) ? m_lim + 1 : m_lim;
                else             m_lim = (m_lim > MIN_D) ? m_lim - 1 : m_lim;
            end
            m_late = 0; m_use = 0; m_evt = 0;
        end else begin
            m_late = nl; m_use = nu; m_evt = (sum > 255) ? 255 : sum;
        end
        @(posedge clk);
        @(negedge clk);
        chk(int'(occupancy) == m_occ, "R4 occupancy", int'(occupancy), m_occ);
        chk(int'(cur_limit) == m_lim, "R6 R7 limit", int'(cur_limit), m_lim);
    endtask

    initial begin
        int lim0;
        process::self().srandom(32'd20250607);
        m_occ = 0; m_lim = INIT_D; m_late = 0; m_use = 0; m_evt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(occupancy == 0, "R1 reset occupancy", int'(occupancy), 0);
        chk(cur_limit == DW'(INIT_D), "R1 reset limit", int'(cur_limit), INIT_D);

        // R3: get on empty queue
        step(0, 1, 0, 0, 0, 0);
        chk(occupancy == 0, "R3 empty get", int'(occupancy), 0);
        // R2: fill past the limit
        repeat (INIT_D + 2) step(1, 0, 0, 0, 0, 0);
        chk(occupancy == DW'(INIT_D), "R2 full put", int'(occupancy), INIT_D);
        // R4: put and get together at the limit: put refused, get accepted
        step(1, 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        chk(occupancy == DW'(INIT_D - 1), "R4 simultaneous", int'(occupancy), INIT_D - 1);
        step(1, 0, 0, 0, 0, 0);

        // R5: strobe with buffer full holds the limit
        step(0, 0, 1, 0, 1, 1);
        chk(cur_limit == DW'(INIT_D), "R5 freeze", int'(cur_limit), INIT_D);
        // R6: late dominates -> grow
        step(0, 0, 1, 1, 1, 0);
        chk(cur_limit == DW'(INIT_D + 1), "R6 grow", int'(cur_limit), INIT_D + 1);
        // R7: equal 2*late vs useful fails strict test -> shrink
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0);
        step(0, 0, 0, 1, 1, 0);
        chk(cur_limit == DW'(INIT_D), "R7 shrink on tie", int'(cur_limit), INIT_D);

        // R10: shrink below occupancy (occupancy 4, limit to 3 then 2)
        step(0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 0);
        chk(occupancy == DW'(INIT_D), "R10 tokens kept", int'(occupancy), INIT_D);
        chk(!put_ready, "R10 put blocked", int'(put_ready), 0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0);
        chk(!put_ready, "R10 blocked at limit", int'(put_ready), 0);
        step(0, 1, 0, 0, 0, 0);
        chk(put_ready, "R10 reopened", int'(put_ready), 1);
        // R7: saturation at MIN_DEPTH
        step(0, 0, 0, 0, 1, 0);
        chk(cur_limit == DW'(MIN_D), "R7 min saturation", int'(cur_limit), MIN_D);

        // R8: window of 4 events, late pulses grow
        evt_window = 8'd4;
        lim0 = m_lim;
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        chk(int'(cur_limit) == lim0, "R8 before window", int'(cur_limit), lim0);
        step(0, 0, 1, 0, 0, 0);
        chk(int'(cur_limit) == lim0 + 1, "R8 window reached", int'(cur_limit), lim0 + 1);
        // R9: counts restarted, three more events do not adapt
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0);
        chk(int'(cur_limit) == lim0 + 1, "R9 restart", int'(cur_limit), lim0 + 1);
        step(0, 0, 0, 0, 1, 1);

        // R6: saturation at MAX_DEPTH
        evt_window = 8'd0;
        repeat (MAX_D + 2) step(0, 0, 1, 0, 1, 0);
        chk(cur_limit == DW'(MAX_D), "R6 max saturation", int'(cur_limit), MAX_D);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            evt_window = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom % 12);
            step($urandom % 3 != 0, $urandom % 2 == 0, $urandom % 3 == 0,
                 $urandom % 2 == 0, $urandom % 40 == 0, $urandom % 5 == 0);
        end

        // R11: useful counter saturates (wrap would flip to grow)
        evt_window = 8'd0;
        step(0, 0, 0, 0, 1, 1);
        lim0 = m_lim;
        for (int i = 0; i < 70000; i++) step(0, 0, i < 32767, 1, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk(int'(cur_limit) == ((lim0 > MIN_D) ? lim0 - 1 : lim0), "R11 useful sat",
            int'(cur_limit), (lim0 > MIN_D) ? lim0 - 1 : lim0);
        // R11: late counter saturates and doubled value does not overflow
        lim0 = m_lim;
        for (int i = 0; i < 70000; i++) step(0, 0, 1, i < 65535, 0, 0);
        step(0, 0, 0, 0, 1, 0);
        chk(int'(cur_limit) == ((lim0 < MAX_D) ? lim0 + 1 : lim0), "R11 late sat",
            int'(cur_limit), (lim0 < MAX_D) ? lim0 + 1 : lim0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule